// File: doc/BRIEF.md
# Modulation Mode Selector with Duty Slew Limit

This block sits between an open-loop current controller and a PWM generator in a soft-switching converter. Once per control tick it receives three precomputed candidates: a switching period worked out at 50 % duty, a duty cycle worked out at the shortest allowed period, and a pulse-skip on-count. From these it picks the operating region:

- **Frequency modulation** for high power.
- **Duty-cycle modulation** for medium power.
- **Pulse skipping** for low power.
- **Disabled** when even one pulse per frame is too many.

It then registers the four generator parameters: period, duty, on-pulses and pulses per frame. The candidates themselves are computed elsewhere; this block does no division and no square root.

Duty is held in thousandths, so 500 means 0.5 and 200 means 0.2. Period is held in clock cycles. The on-count candidate is unsigned fixed point with `PON_FRAC` fractional bits (4 by default, so 16 means one pulse).

Duty never moves by more than `D_STEP` per tick, measured from the duty issued at the previous tick. This limits the voltage slope across the DC blocking capacitor. All outputs change only on the tick strobe.

Top module: `mod_mode_sel`

## Requirements
- R1: After reset the outputs are: period = `TP_MIN` (500), duty = 200, on-pulses = 0, pulses per frame = 5, mode = 2'b11, and the enable is low.
- R2: With `tick` low, every output holds its value whatever the candidate inputs do.
- R3: A candidate period strictly above `TP_MIN` selects frequency modulation (mode 2'b10). The candidate period is issued, the duty target is 500, on-pulses = 1, pulses per frame = 1, and the enable is high.
- R4: In frequency modulation the issued period is clamped to `TP_MAX` (2000).
- R5: A candidate period at or below `TP_MIN` with a duty candidate of at least 200 selects duty modulation (mode 2'b01). The period is `TP_MIN`, the duty target is the candidate capped at 500, and on-pulses = pulses per frame = 1.
- R6: A candidate period at or below `TP_MIN` with a duty candidate below 200 selects pulse skipping (mode 2'b00). The duty target is 200 and pulses per frame = 5. On-pulses is the on-count candidate rounded half-up to an integer and saturated at 5.
- R7: The issued duty differs from the previously issued duty by at most 20 per tick, moves toward the target, and is never below 200.
- R8: In the pulse-skip region, an on-count candidate that rounds to zero (below 0.5, i.e. below 8 in 1/16 units) gives mode 2'b11. In this mode the enable is low, on-pulses = 0, pulses per frame = 5 and period = `TP_MIN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Control iteration strobe |
| cand_period | input | 16 | Period candidate at 50 % duty, clock cycles |
| cand_duty | input | 10 | Duty candidate at minimum period, thousandths |
| cand_pon | input | 8 | On-count candidate, fixed point with 4 fractional bits |
| period_o | output | 16 | Issued switching period |
| duty_o | output | 10 | Issued duty, thousandths |
| pon_o | output | 4 | On-pulses per frame |
| pframe_o | output | 4 | Pulses per frame |
| mode_o | output | 2 | 00 skip, 01 duty, 10 frequency, 11 disabled |
| pwm_en_o | output | 1 | PWM output enable |

## Verification
The vector walk starts at the reset duty. It climbs through frequency modulation, including a period above the ceiling, so the duty ramp in steps of 20 is visible against a target of 500.

It then drops to duty modulation with targets inside, below and above the slew window. This separates the slew clamp from the 0.5 cap.

The pulse-skip vectors probe the on-count at 0.4375, at 0.5, at a mid value and at a value above the frame. These tell rounding apart from saturation and from the disable path.

Boundary vectors check a period exactly at and one above the minimum, and a duty exactly at and one below 0.2. These pin down the strictness of each comparison.

// File: rtl/mod_mode_sel.sv
module mod_mode_sel #(
  parameter int PW       = 16,
  parameter int DW       = 10,
  parameter int PONW     = 8,
  parameter int PON_FRAC = 4,
  parameter int CW       = 4,
  parameter int TP_MIN   = 500,
  parameter int TP_MAX   = 2000,
  parameter int D_HALF   = 500,
  parameter int D_MIN    = 200,
  parameter int D_STEP   = 20,
  parameter int PC_FRAME = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] cand_period,
  input  logic [DW-1:0] cand_duty,
  input  logic [PONW-1:0] cand_pon,
  output logic [PW-1:0] period_o,
  output logic [DW-1:0] duty_o,
  output logic [CW-1:0] pon_o,
  output logic [CW-1:0] pframe_o,
  output logic [1:0]    mode_o,
  output logic          pwm_en_o
);

  localparam logic [PW-1:0]   TPMIN_C = PW'(TP_MIN);
  localparam logic [PW-1:0]   TPMAX_C = PW'(TP_MAX);
  localparam logic [DW:0]     DHALF_C = (DW+1)'(D_HALF);
  localparam logic [DW:0]     DMIN_C  = (DW+1)'(D_MIN);
  localparam logic [DW:0]     DSTEP_C = (DW+1)'(D_STEP);
  localparam logic [CW-1:0]   FRAME_C = CW'(PC_FRAME);
  localparam logic [PONW:0]   PHALF_C = (PONW+1)'(1 << (PON_FRAC-1));
  localparam logic [1:0] M_SKIP = 2'b00, M_DUTY = 2'b01, M_FREQ = 2'b10, M_OFF = 2'b11;

  logic          fm_sel, skip_sel, off_sel;
  logic [PONW:0] pon_round;
  logic [CW-1:0] pon_sat;
  logic [DW:0]   cand_d, target, prev, up, lo, d_next;
  logic [PW-1:0] per_next;
  logic [1:0]    mode_next;

  assign fm_sel    = cand_period > TPMIN_C;
  assign cand_d    = {1'b0, cand_duty};
  assign skip_sel  = !fm_sel && (cand_d < DMIN_C);
  assign pon_round = ({1'b0, cand_pon} + PHALF_C) >> PON_FRAC;
  assign pon_sat   = (pon_round > (PONW+1)'(PC_FRAME)) ? FRAME_C : pon_round[CW-1:0];
  assign off_sel   = skip_sel && (pon_round == '0);

  assign target = fm_sel   ? DHALF_C :
                  skip_sel ? DMIN_C  :
                  (cand_d > DHALF_C) ? DHALF_C : cand_d;

  assign prev   = {1'b0, duty_o};
  assign up     = prev + DSTEP_C;
  assign lo     = (prev > DMIN_C + DSTEP_C) ? prev - DSTEP_C : DMIN_C;
  assign d_next = (target > up) ? up : (target < lo) ? lo : target;

  assign per_next  = !fm_sel ? TPMIN_C : (cand_period > TPMAX_C) ? TPMAX_C : cand_period;
  assign mode_next = fm_sel ? M_FREQ : off_sel ? M_OFF : skip_sel ? M_SKIP : M_DUTY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_o <= TPMIN_C;
      duty_o   <= DMIN_C[DW-1:0];
      pon_o    <= '0;
      pframe_o <= FRAME_C;
      mode_o   <= M_OFF;
      pwm_en_o <= 1'b0;
    end else if (tick) begin
      period_o <= per_next;
      duty_o   <= d_next[DW-1:0];
      mode_o   <= mode_next;
      pwm_en_o <= !off_sel;
      pon_o    <= off_sel ? '0 : skip_sel ? pon_sat : CW'(1);
      pframe_o <= skip_sel ? FRAME_C : CW'(1);
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(duty_o) && $stable(period_o) && $stable(mode_o) && $stable(pon_o))); // R2
  AST_SLEW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ({1'b0, duty_o} <= {1'b0, $past(duty_o)} + DSTEP_C)); // R7
  AST_SLEW_DN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ({1'b0, duty_o} + DSTEP_C >= {1'b0, $past(duty_o)})); // R7
  AST_DUTY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, duty_o} >= DMIN_C); // R7
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o >= TPMIN_C) && (period_o <= TPMAX_C)); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_OFF) |-> (!pwm_en_o && pon_o == '0)); // R8
  AST_PON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    pon_o <= pframe_o); // R6
  AST_FIXED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != M_FREQ) |-> (period_o == TPMIN_C)); // R5

endmodule

// File: tb/mod_mode_sel_test.sv
module mod_mode_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // period, duty, pon | exp period, duty, po, pc, mode
  localparam int VEC [NV][8] = '{
    '{ 800, 300,   0,  800, 220, 1, 1, 2},
    '{2500,   0,   0, 2000, 240, 1, 1, 2},
    '{ 500, 250,   0,  500, 250, 1, 1, 1},
    '{ 400, 450,   0,  500, 270, 1, 1, 1},
    '{ 400, 900,   0,  500, 290, 1, 1, 1},
    '{ 300, 100,  40,  500, 270, 3, 5, 0},
    '{ 300, 150, 120,  500, 250, 5, 5, 0},
    '{ 300, 150,   7,  500, 230, 0, 5, 3},
    '{ 300, 150,   8,  500, 210, 1, 5, 0},
    '{ 500, 210,   0,  500, 210, 1, 1, 1},
    '{ 501,   0,   0,  501, 230, 1, 1, 2},
    '{ 300, 199,  16,  500, 210, 1, 5, 0},
    '{ 300, 200,   0,  500, 200, 1, 1, 1}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic [15:0] cand_period = 0;
  logic [9:0]  cand_duty = 0;
  logic [7:0]  cand_pon = 0;
  logic [15:0] period_o;
  logic [9:0]  duty_o;
  logic [3:0]  pon_o, pframe_o;
  logic [1:0]  mode_o;
  logic        pwm_en_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_mode_sel uut (.clk(clk), .rst_n(rst_n), .tick(tick), .cand_period(cand_period),
    .cand_duty(cand_duty), .cand_pon(cand_pon), .period_o(period_o), .duty_o(duty_o),
    .pon_o(pon_o), .pframe_o(pframe_o), .mode_o(mode_o), .pwm_en_o(pwm_en_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset(input string req);
    chk(req, "period", int'(period_o), 500);
    chk(req, "duty", int'(duty_o), 200);
    chk(req, "pon", int'(pon_o), 0);
    chk(req, "pframe", int'(pframe_o), 5);
    chk(req, "mode", int'(mode_o), 3);
    chk(req, "enable", int'(pwm_en_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_reset("R1");
    for (int i = 0; i < NV; i++) begin
      cand_period = 16'(VEC[i][0]);
      cand_duty   = 10'(VEC[i][1]);
      cand_pon    = 8'(VEC[i][2]);
      tick = 1;
      @(negedge clk);
      tick = 0;
      // R3 R4 R5 R6 R7 R8 per row
      chk("R3/R4/R5 period", $sformatf("row %0d", i), int'(period_o), VEC[i][3]);
      chk("R7 duty", $sformatf("row %0d", i), int'(duty_o), VEC[i][4]);
      chk("R6 pon", $sformatf("row %0d", i), int'(pon_o), VEC[i][5]);
      chk("R6 pframe", $sformatf("row %0d", i), int'(pframe_o), VEC[i][6]);
      chk("R8 mode", $sformatf("row %0d", i), int'(mode_o), VEC[i][7]);
      chk("R8 enable", $sformatf("row %0d", i), int'(pwm_en_o), (VEC[i][7] == 3) ? 0 : 1);
    end
    // R2: inputs move without a tick, outputs hold
    cand_period = 1500; cand_duty = 50; cand_pon = 0;
    repeat (4) @(negedge clk);
    chk("R2", "period hold", int'(period_o), 500);
    chk("R2", "duty hold", int'(duty_o), 200);
    chk("R2", "mode hold", int'(mode_o), 1);
    chk("R2", "enable hold", int'(pwm_en_o), 1);
    // R3 ramp: repeated frequency ticks climb by 20 up to 500 then stay
    cand_duty = 0;
    for (int k = 1; k <= 17; k++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
      chk("R3 ramp", $sformatf("tick %0d", k), int'(duty_o), (200 + 20*k > 500) ? 500 : 200 + 20*k);
    end
    chk("R4", "period in range", int'(period_o), 1500);
    // R1 again after a mid-run reset
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check_reset("R1 rerun");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule